// File: doc/BRIEF.md
# Cascadable Decimal Counter Digit

This block is one decimal digit of a synchronous counter. It holds a 4-bit count that steps 0, 1, ... 9, 0 on rising clock edges. An active-low clear input sets the count to zero at once, with no clock edge needed. An active-low load input makes the next rising edge copy a 4-bit preset value into the count.

Counting needs two enables, and both must be high. The carry enable also qualifies the carry output, which is high while the digit shows its top value. The local enable does not affect the carry. To build a multi-digit counter, tie the local enables of all digits to one shared count-enable. Feed each digit's carry into the carry enable of the next, more significant digit. The carry ripples through combinational logic only, so every digit updates on the same clock edge.

A preset value from 10 to 15 is accepted as it is. The digit then counts up in plain binary and wraps from 15 to 0. It never raises the carry while it is in that range.

Top module: `bcd_stage`

## Requirements
- R1: While `clr_n` is low, `count` is 0, even between clock edges and with no clock edge since the clear went low.
- R2: With `clr_n` high and `load_n` low at a rising edge, `count` takes the value of `preset` on that edge, whatever the two enables are.
- R3: With `clr_n` and `load_n` high and both `en_local` and `en_chain` high, a rising edge adds one to `count` when `count` is 0 to 8 or 10 to 14.
- R4: With `clr_n` and `load_n` high and either enable low, `count` keeps its value across a rising edge.
- R5: A counting edge taken at `count` = 9 gives `count` = 0.
- R6: `carry_out` is high exactly when `count` equals 9 and `en_chain` is high, in the same cycle and with no register in between. `en_local` has no effect on it.
- R7: A counting edge taken at `count` = 15 gives 0. `carry_out` stays low for every count from 10 to 15.
- R8: A low `clr_n` overrides a load request and any counting. The count stays 0 across rising edges while `clr_n` is low.
- R9: Two digits chained carry-to-carry-enable form a two-digit decimal counter. It counts from 99 to 00 on a single edge, and both carries are high at 99.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count changes on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous load request, active low |
| preset | input | 4 | Value copied into the count on a load |
| en_local | input | 1 | Count enable that does not gate the carry |
| en_chain | input | 1 | Count enable that also qualifies the carry |
| count | output | 4 | Current digit value |
| carry_out | output | 1 | High at count 9 while en_chain is high |

## Verification
The assertions check on every cycle:
- the priority between clear, load, count and hold;
- the one-step advance and the two wrap points;
- the rule that the carry is high only at 9 with the carry enable high.

Other behaviours show up only in the bench's scenarios:
- a clear that arrives between two edges and takes effect at once;
- the timing across two chained digits, where the upper digit must advance on the very edge at which the lower digit wraps, giving 99 to 00;
- a load in the middle of a running count.

Random control sequences, with loads of out-of-range values mixed in, cover the mix of those cases.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

    localparam int DIGIT_W   = 4;
    localparam int DIGIT_TOP = 9;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_COUNT = 2'd2
    } act_e;

    // Clear is handled asynchronously in the state register; here load
    // outranks counting, and counting needs both enables.
    function automatic act_e pick_act(input logic load_n,
                                      input logic en_local,
                                      input logic en_chain);
        if (!load_n)
            return ACT_LOAD;
        else if (en_local && en_chain)
            return ACT_COUNT;
        else
            return ACT_HOLD;
    endfunction

endpackage

// File: rtl/bcd_next.sv
module bcd_next #(
    parameter int WIDTH = bcd_pkg::DIGIT_W,
    parameter int TOP   = bcd_pkg::DIGIT_TOP
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] preset,
    input  bcd_pkg::act_e    act,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] TOP_V = WIDTH'(TOP);

    logic [WIDTH-1:0] inc_val;

    // Decimal wrap at TOP; values above TOP wrap naturally in binary.
    always_comb begin
        if (cur == TOP_V)
            inc_val = '0;
        else
            inc_val = cur + 1'b1;
    end

    always_comb begin
        case (act)
            bcd_pkg::ACT_LOAD:  nxt = preset;
            bcd_pkg::ACT_COUNT: nxt = inc_val;
            default:            nxt = cur;
        endcase
    end
endmodule

// File: rtl/bcd_state.sv
module bcd_state #(
    parameter int WIDTH = bcd_pkg::DIGIT_W
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)
            q <= '0;
        else
            q <= d;
    end

    // R1 / R8: held at zero on every edge while clear is low
    p_clear_hold_r8: assert property (@(posedge clk) !clr_n |-> q == '0)
        else $error("state not cleared");
endmodule

// File: rtl/bcd_carry.sv
module bcd_carry #(
    parameter int WIDTH = bcd_pkg::DIGIT_W,
    parameter int TOP   = bcd_pkg::DIGIT_TOP
) (
    input  logic [WIDTH-1:0] cnt,
    input  logic             en_chain,
    output logic             tc
);
    localparam logic [WIDTH-1:0] TOP_V = WIDTH'(TOP);

    assign tc = (cnt == TOP_V) && en_chain;
endmodule

// File: rtl/bcd_stage.sv
module bcd_stage #(
    parameter int WIDTH = bcd_pkg::DIGIT_W,
    parameter int TOP   = bcd_pkg::DIGIT_TOP
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] preset,
    input  logic             en_local,
    input  logic             en_chain,
    output logic [WIDTH-1:0] count,
    output logic             carry_out
);
    localparam logic [WIDTH-1:0] TOP_V = WIDTH'(TOP);
    localparam logic [WIDTH-1:0] MAX_V = {WIDTH{1'b1}};

    bcd_pkg::act_e    act;
    logic [WIDTH-1:0] nxt;

    assign act = bcd_pkg::pick_act(load_n, en_local, en_chain);

    bcd_next #(.WIDTH(WIDTH), .TOP(TOP)) u_next (
        .cur    (count),
        .preset (preset),
        .act    (act),
        .nxt    (nxt)
    );

    bcd_state #(.WIDTH(WIDTH)) u_state (
        .clk   (clk),
        .clr_n (clr_n),
        .d     (nxt),
        .q     (count)
    );

    bcd_carry #(.WIDTH(WIDTH), .TOP(TOP)) u_carry (
        .cnt      (count),
        .en_chain (en_chain),
        .tc       (carry_out)
    );

    p_clear_r1: assert property (@(posedge clk) !clr_n |-> count == '0)
        else $error("count not zero under clear");

    p_load_r2: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> count == $past(preset))
        else $error("load not taken");

    p_step_r3: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_local && en_chain && count != TOP_V && count != MAX_V)
        |=> count == WIDTH'($past(count) + 1'b1))
        else $error("count did not advance");

    p_hold_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_local && en_chain)) |=> $stable(count))
        else $error("count moved while disabled");

    p_wrap_r5: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_local && en_chain && count == TOP_V) |=> count == '0)
        else $error("no decimal wrap");

    p_carry_r6: assert property (@(posedge clk) disable iff (!clr_n)
        carry_out |-> (count == TOP_V && en_chain))
        else $error("spurious carry");

    p_carry_on_r6: assert property (@(posedge clk) disable iff (!clr_n)
        (count == TOP_V && en_chain) |-> carry_out)
        else $error("missing carry");

    p_range_r7: assert property (@(posedge clk) disable iff (!clr_n)
        (count > TOP_V) |-> !carry_out)
        else $error("carry out of range");

    p_binwrap_r7: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_local && en_chain && count == MAX_V) |=> count == '0)
        else $error("no binary wrap");
endmodule

// File: tb/test_bcd_stage.sv
`timescale 1ns/1ps
module test_bcd_stage;
    logic       clk = 1'b0;
    logic       clr_n = 1'b1;
    logic       load_n = 1'b1;
    logic [3:0] pre_lo = 4'd0, pre_hi = 4'd0;
    logic       en_p = 1'b0, en_t = 1'b0;
    logic [3:0] cnt_lo, cnt_hi;
    logic       tc_lo, tc_hi;

    logic [3:0] m_lo = 4'd0, m_hi = 4'd0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bcd_stage i_bcd_stage (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .preset(pre_lo),
        .en_local(en_p), .en_chain(en_t), .count(cnt_lo), .carry_out(tc_lo)
    );

    bcd_stage i_bcd_stage_hi (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .preset(pre_hi),
        .en_local(en_p), .en_chain(tc_lo), .count(cnt_hi), .carry_out(tc_hi)
    );

    function automatic logic carry_f(logic [3:0] c, logic e);
        return (c == 4'd9) && e;
    endfunction

    function automatic logic [3:0] next_f(logic [3:0] c, logic ld_n,
                                          logic [3:0] p, logic a, logic b);
        if (!ld_n) return p;
        if (a && b) return (c == 4'd9) ? 4'd0 : c + 4'd1;
        return c;
    endfunction

    task automatic chk(string tag);
        logic elo, ehi;
        elo = carry_f(m_lo, en_t);
        ehi = carry_f(m_hi, elo);
        checks++;
        if (cnt_lo !== m_lo || cnt_hi !== m_hi || tc_lo !== elo || tc_hi !== ehi) begin
            fails++;
            $display("FAIL %s: got lo=%0d hi=%0d tc=%b%b expected lo=%0d hi=%0d tc=%b%b",
                     tag, cnt_lo, cnt_hi, tc_lo, tc_hi, m_lo, m_hi, elo, ehi);
        end
    endtask

    task automatic step(string tag);
        logic [3:0] nl, nh;
        @(posedge clk);
        if (!clr_n) begin
            nl = 4'd0; nh = 4'd0;
        end else begin
            nl = next_f(m_lo, load_n, pre_lo, en_p, en_t);
            nh = next_f(m_hi, load_n, pre_hi, en_p, carry_f(m_lo, en_t));
        end
        m_lo = nl; m_hi = nh;
        @(negedge clk);
        chk(tag);
    endtask

    task automatic load2(logic [3:0] hi, logic [3:0] lo, string tag);
        load_n = 1'b0; pre_hi = hi; pre_lo = lo;
        step(tag);
        load_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned r;
        r = $urandom(32'd4711);
        // R1: clear asserted before any edge
        #1 clr_n = 1'b0;
        @(negedge clk);
        chk("R1 reset state");
        clr_n = 1'b1;

        // R3 R5 R9: count 00 up past 99
        load2(4'd0, 4'd0, "R2 load 00");
        en_p = 1'b1; en_t = 1'b1;
        for (int i = 0; i < 99; i++) step("R3 R5 count");
        if (cnt_hi == 4'd9 && cnt_lo == 4'd9) chk("R9 at 99 both carries");
        step("R9 rollover 99 to 00");
        for (int i = 0; i < 5; i++) step("R3 after rollover");

        // R2: load in the middle of counting
        load2(4'd5, 4'd3, "R2 mid-count load");
        step("R3 after load");

        // R4: hold with either enable low
        en_p = 1'b0;
        for (int i = 0; i < 3; i++) step("R4 hold local low");
        en_p = 1'b1; en_t = 1'b0;
        for (int i = 0; i < 3; i++) step("R4 hold chain low");

        // R6: carry ignores en_local
        load2(4'd2, 4'd9, "R2 load 29");
        en_p = 1'b0; en_t = 1'b1;
        step("R6 carry with local low");
        en_t = 1'b0;
        step("R6 carry off chain low");

        // R7: out-of-range values
        en_p = 1'b1; en_t = 1'b1;
        load2(4'd0, 4'd12, "R7 load 12");
        for (int i = 0; i < 6; i++) step("R7 binary wrap no carry");

        // R1 R8: clear between edges, with a load pending
        #1 clr_n = 1'b0;
        #0.5;
        m_lo = 4'd0; m_hi = 4'd0;
        chk("R1 clear between edges");
        load_n = 1'b0; pre_lo = 4'd7; pre_hi = 4'd4;
        step("R8 clear beats load");
        step("R8 clear beats load again");
        clr_n = 1'b1; load_n = 1'b1;
        step("R3 count after clear");

        // random mix
        for (int i = 0; i < 400; i++) begin
            r = $urandom;
            load_n = (r[3:0] != 4'd0);
            pre_lo = r[7:4]; pre_hi = r[11:8];
            en_p = (r[13:12] != 2'd0);
            en_t = (r[15:14] != 2'd0);
            step("R2 R3 R4 R6 R7 random");
        end
        finish_run();
    end
endmodule